// File: doc/BRIEF.md
# Serial Cell Receive Deframer

This block sits behind a clock-recovery stage and takes one recovered line bit per clock, qualified by an enable. It removes the NRZI line coding, gathers the bits into 5-bit symbols and maps each symbol to a 4-bit nibble through a code table given as a parameter. Two consecutive nibbles, high nibble first, form one byte. The symbol boundary is found and held without any external help. A decode failure moves the boundary by one bit. While the block holds no alignment, seeing the escape code snaps the boundary to that symbol at once.

A command is an escape symbol followed by one more symbol. Escape then the 8 code is a timing marker. It produces a single low cycle on `marker_n_o`. Escape then escape, or escape then the 4 code, opens a cell. The next 53 bytes leave on `byte_o` with `byte_vld_o`, and `sof_o` marks the first of them. Data symbols that arrive with no cell open are discarded. A one-cycle `bad_sym_o` strobe reports every symbol that is neither a table entry nor the escape code.

Top module: `ser_cell_deframer`

## Requirements
- R1: A line bit that differs from the previous enabled line bit is decoded as 1. An equal line bit is decoded as 0. The previous-level register is 0 after reset.
- R2: Symbols are 5 bits and arrive most significant bit first. A byte is {first nibble, second nibble}, and its value equals the table indices of the two symbols.
- R3: While unaligned, including straight after reset, the escape code 5'b00010 sets the symbol boundary at the bit that completes it, whatever the earlier bit offset.
- R4: A completed symbol that is neither in the table nor the escape code raises `bad_sym_o` for exactly one cycle. It clears alignment and makes the next symbol one bit longer.
- R5: Escape followed by the symbol for nibble 8 gives exactly one cycle of `marker_n_o` low and produces no byte.
- R6: Escape followed by escape, or by the symbol for nibble 4, opens a cell of exactly 53 bytes. Each byte has `byte_vld_o` high for one cycle, and `sof_o` is high only with the first byte.
- R7: Data symbols received while no cell is open produce no byte.
- R8: After reset `marker_n_o` is 1, and `byte_vld_o`, `sof_o` and `bad_sym_o` are 0.
- R9: A cycle with `bit_en_i` low consumes no bit. Output bytes are the same with any number of idle cycles between bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Recovered bit is valid this cycle |
| line_i | input | 1 | Recovered NRZI line level |
| byte_o | output | 8 | Cell byte |
| byte_vld_o | output | 1 | `byte_o` valid |
| sof_o | output | 1 | First byte of a cell |
| marker_n_o | output | 1 | Timing marker pulse, active low |
| bad_sym_o | output | 1 | Undecodable symbol strobe |

## Verification
The bench sweeps every starting bit offset of the first escape code behind a run of undecodable zeros. A design that required the hunt to land on a fixed phase would lose the marker on most offsets. Each offset is run with both cell-opening commands and with and without idle cycles between bits. A wrong command compare or a bit taken on a disabled cycle would show up as a missing cell or corrupted bytes. After each cell the bench sends extra data symbols, which must yield nothing, so an off-by-one cell length or a cell that never closes is caught. It then injects a bad symbol and a fresh marker. This shows that the slip, the loss of lock and the escape re-alignment work together rather than leaving the framer stuck.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int SYM_W   = 5;
  localparam int NIB_W   = 4;
  localparam int NUM_SYM = 1 << NIB_W;
  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/sdf_nrzi_dec.sv
module sdf_nrzi_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line_i,
  output logic bit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prev_q <= 1'b0;
    else if (en_i) prev_q <= line_i;
  end

  assign bit_o = line_i ^ prev_q;
endmodule

// File: rtl/sdf_sym_align.sv
module sdf_sym_align import sdf_pkg::*; #(
  parameter sym_t ESC_SYM = 5'b00010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  input  logic bad_i,
  output sym_t sym_o,
  output logic sym_vld_o
);
  localparam int CW = $clog2(SYM_W);
  localparam logic [CW-1:0] LAST = CW'(SYM_W - 1);

  sym_t          sr_q, sym_q, win;
  logic [CW-1:0] cnt_q;
  logic          vld_q, locked_q, slip_q;
  logic          force_aln, skip;

  assign win       = {sr_q[SYM_W-2:0], bit_i};
  assign force_aln = bit_en_i && !locked_q && (win == ESC_SYM);
  assign skip      = slip_q || bad_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      sym_q    <= '0;
      cnt_q    <= '0;
      vld_q    <= 1'b0;
      locked_q <= 1'b0;
      slip_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (vld_q) locked_q <= !bad_i;
      if (bad_i) slip_q <= 1'b1;
      if (bit_en_i) begin
        sr_q <= win;
        if (force_aln) begin
          cnt_q    <= '0;
          sym_q    <= win;
          vld_q    <= 1'b1;
          locked_q <= 1'b1;
          slip_q   <= 1'b0;
        end else if (skip) begin
          slip_q <= 1'b0;          // drop this bit from the count: one-bit slip
        end else if (cnt_q == LAST) begin
          cnt_q <= '0;
          sym_q <= win;
          vld_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sym_o     = sym_q;
  assign sym_vld_o = vld_q;
endmodule

// File: rtl/sdf_sym_decode.sv
module sdf_sym_decode import sdf_pkg::*; #(
  parameter logic [NUM_SYM*SYM_W-1:0] SYM_TABLE = '0,
  parameter sym_t                     ESC_SYM   = 5'b00010
) (
  input  sym_t sym_i,
  input  logic vld_i,
  output nib_t nib_o,
  output logic esc_o,
  output logic bad_o
);
  logic [NUM_SYM-1:0] hit;

  for (genvar g = 0; g < NUM_SYM; g++) begin : g_cmp
    assign hit[g] = (sym_i == SYM_TABLE[g*SYM_W +: SYM_W]);
  end

  always_comb begin
    nib_o = '0;
    for (int i = 0; i < NUM_SYM; i++)
      if (hit[i]) nib_o = NIB_W'(i);
  end

  assign esc_o = (sym_i == ESC_SYM);
  assign bad_o = vld_i && !(|hit) && !esc_o;
endmodule

// File: rtl/sdf_cell_ctl.sv
module sdf_cell_ctl import sdf_pkg::*; #(
  parameter int   CELL_BYTES = 53,
  parameter nib_t MARK_NIB   = 4'h8,
  parameter nib_t SOC_NIB    = 4'h4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vld_i,
  input  nib_t       nib_i,
  input  logic       esc_i,
  input  logic       bad_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       sof_o,
  output logic       marker_n_o
);
  localparam int BCW = $clog2(CELL_BYTES + 1);
  localparam logic [BCW-1:0] LAST = BCW'(CELL_BYTES - 1);

  logic [BCW-1:0] bcnt_q;
  nib_t           hi_q;
  logic           hi_have_q, esc_seen_q, in_cell_q;
  logic [7:0]     byte_q;
  logic           bvld_q, sof_q, mark_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q     <= '0;
      hi_q       <= '0;
      hi_have_q  <= 1'b0;
      esc_seen_q <= 1'b0;
      in_cell_q  <= 1'b0;
      byte_q     <= '0;
      bvld_q     <= 1'b0;
      sof_q      <= 1'b0;
      mark_n_q   <= 1'b1;
    end else begin
      bvld_q   <= 1'b0;
      sof_q    <= 1'b0;
      mark_n_q <= 1'b1;
      if (vld_i) begin
        if (bad_i) begin
          esc_seen_q <= 1'b0;
          hi_have_q  <= 1'b0;
        end else if (esc_seen_q) begin
          esc_seen_q <= 1'b0;
          if (esc_i || nib_i == SOC_NIB) begin
            in_cell_q <= 1'b1;
            bcnt_q    <= '0;
            hi_have_q <= 1'b0;
          end else if (nib_i == MARK_NIB) begin
            mark_n_q <= 1'b0;
          end
        end else if (esc_i) begin
          esc_seen_q <= 1'b1;
          in_cell_q  <= 1'b0;
          hi_have_q  <= 1'b0;
        end else if (in_cell_q) begin
          if (!hi_have_q) begin
            hi_q      <= nib_i;
            hi_have_q <= 1'b1;
          end else begin
            hi_have_q <= 1'b0;
            byte_q    <= {hi_q, nib_i};
            bvld_q    <= 1'b1;
            sof_q     <= (bcnt_q == '0);
            bcnt_q    <= bcnt_q + 1'b1;
            if (bcnt_q == LAST) in_cell_q <= 1'b0;
          end
        end
      end
    end
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = bvld_q;
  assign sof_o      = sof_q;
  assign marker_n_o = mark_n_q;
endmodule

// File: rtl/ser_cell_deframer.sv
module ser_cell_deframer import sdf_pkg::*; #(
  parameter logic [NUM_SYM*SYM_W-1:0] SYM_TABLE = {
    5'b11101, 5'b11100, 5'b11011, 5'b11010, 5'b10111, 5'b10110, 5'b10011, 5'b10010,
    5'b01111, 5'b01110, 5'b01011, 5'b01010, 5'b10101, 5'b10100, 5'b01001, 5'b11110},
  parameter sym_t ESC_SYM    = 5'b00010,
  parameter int   CELL_BYTES = 53,
  parameter nib_t MARK_NIB   = 4'h8,
  parameter nib_t SOC_NIB    = 4'h4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       line_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       sof_o,
  output logic       marker_n_o,
  output logic       bad_sym_o
);
  logic dbit, sym_vld, esc, bad;
  sym_t sym;
  nib_t nib;

  sdf_nrzi_dec u_nrzi (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(bit_en_i), .line_i(line_i), .bit_o(dbit)
  );

  sdf_sym_align #(.ESC_SYM(ESC_SYM)) u_align (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .bit_i(dbit),
    .bad_i(bad), .sym_o(sym), .sym_vld_o(sym_vld)
  );

  sdf_sym_decode #(.SYM_TABLE(SYM_TABLE), .ESC_SYM(ESC_SYM)) u_dec (
    .sym_i(sym), .vld_i(sym_vld), .nib_o(nib), .esc_o(esc), .bad_o(bad)
  );

  sdf_cell_ctl #(.CELL_BYTES(CELL_BYTES), .MARK_NIB(MARK_NIB), .SOC_NIB(SOC_NIB)) u_cell (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(sym_vld), .nib_i(nib), .esc_i(esc), .bad_i(bad),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o), .sof_o(sof_o), .marker_n_o(marker_n_o)
  );

  assign bad_sym_o = bad;
endmodule

// File: rtl/ser_cell_deframer_chk.sv
module ser_cell_deframer_chk #(
  parameter int CELL_BYTES = 53
) (
  input logic clk_i,
  input logic rst_ni,
  input logic byte_vld_o,
  input logic sof_o,
  input logic marker_n_o,
  input logic bad_sym_o
);
  logic [7:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         seen_q <= '0;
    else if (byte_vld_o) seen_q <= sof_o ? 8'd1 : seen_q + 8'd1;
  end

  p_sof_vld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> byte_vld_o);

  p_cell_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_o && !sof_o) |-> (seen_q >= 8'd1 && seen_q <= 8'(CELL_BYTES - 1)));

  p_byte_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  p_mark_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !marker_n_o |=> marker_n_o);

  p_mark_no_byte_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !marker_n_o |-> !byte_vld_o);

  p_bad_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_sym_o |=> !bad_sym_o);
endmodule

bind ser_cell_deframer ser_cell_deframer_chk #(.CELL_BYTES(CELL_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_o(byte_vld_o), .sof_o(sof_o),
  .marker_n_o(marker_n_o), .bad_sym_o(bad_sym_o)
);

// File: tb/ser_cell_deframer_tb_top.sv
`timescale 1ns/1ps
module ser_cell_deframer_tb_top;
  localparam logic [4:0] ESC = 5'b00010;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0;
  logic       line_i = 1'b0;
  logic [7:0] byte_o;
  logic       byte_vld_o, sof_o, marker_n_o, bad_sym_o;

  int errors = 0, checks = 0;
  int nbytes = 0, nsof = 0, nmark = 0, nbad = 0;
  int bbase = 0, sof_at = -1, gap = 0;
  logic lvl = 1'b0;
  logic [7:0] cap [0:63];

  always #2.5 clk_i = ~clk_i;

  ser_cell_deframer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .line_i(line_i),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o), .sof_o(sof_o),
    .marker_n_o(marker_n_o), .bad_sym_o(bad_sym_o)
  );

  always @(negedge clk_i) if (rst_ni) begin
    if (byte_vld_o) begin
      if (nbytes >= bbase && nbytes - bbase < 64) cap[nbytes - bbase] = byte_o;
      if (sof_o) begin nsof++; sof_at = nbytes - bbase; end
      nbytes++;
    end
    if (!marker_n_o) nmark++;
    if (bad_sym_o) nbad++;
  end

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011; 4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(input int run, input int k);
    exp_byte = 8'(run * 37 + k * 13 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: a 1 toggles the line level, a 0 leaves it
  task automatic send_bit(input logic b);
    lvl = lvl ^ b;
    line_i = lvl;
    bit_en_i = 1'b1;
    @(negedge clk_i);
    bit_en_i = 1'b0;
    repeat (gap) @(negedge clk_i);
  endtask

  task automatic send_sym(input logic [4:0] s);
    for (int i = 4; i >= 0; i--) send_bit(s[i]);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    bit_en_i = 1'b0;
    lvl = 1'b0;
    line_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic run(input int id, input int off, input int g, input bit soc4);
    int b0, m0, bad0, mism, first;
    string tg;
    tg = g ? "R9" : "R2";
    gap = 0;
    do_reset();
    chk(marker_n_o === 1'b1 && byte_vld_o === 1'b0 && sof_o === 1'b0 && bad_sym_o === 1'b0,
        "R8 reset outputs", {marker_n_o, byte_vld_o, sof_o, bad_sym_o}, 4'b1000);
    gap = g;
    m0 = nmark;
    b0 = nbytes;
    // R3: hunt from any bit offset
    repeat (3 + off) send_bit(1'b0);
    send_sym(ESC);
    send_sym(enc(4'h8));
    settle();
    chk(nmark - m0 == 1, "R3 R5 marker after hunt", nmark - m0, 1);
    chk(nbytes == b0, "R5 marker makes no byte", nbytes - b0, 0);

    bbase = nbytes;
    sof_at = -1;
    b0 = nsof;
    send_sym(ESC);
    send_sym(soc4 ? enc(4'h4) : ESC);
    for (int k = 0; k < 53; k++) begin
      send_sym(enc(exp_byte(id, k)[7:4]));
      send_sym(enc(exp_byte(id, k)[3:0]));
    end
    settle();
    chk(nbytes - bbase == 53, "R6 cell length", nbytes - bbase, 53);
    chk(nsof - b0 == 1 && sof_at == 0, "R6 sof on first byte", sof_at, 0);
    mism = 0;
    first = -1;
    for (int k = 0; k < 53; k++)
      if (cap[k] !== exp_byte(id, k)) begin
        mism++;
        if (first < 0) first = k;
      end
    if (first < 0) first = 0;
    chk(mism == 0, {tg, " R1 cell bytes"}, cap[first], exp_byte(id, first));

    // R7: data after the cell closes is discarded
    b0 = nbytes;
    for (int k = 0; k < 4; k++) send_sym(enc(4'(k + off)));
    settle();
    chk(nbytes == b0, "R7 idle data dropped", nbytes - b0, 0);

    // R4: bad symbol flagged, then escape realigns
    bad0 = nbad;
    m0 = nmark;
    send_sym(5'b00000);
    settle();
    chk(nbad - bad0 == 1, "R4 bad symbol strobe", nbad - bad0, 1);
    send_sym(ESC);
    send_sym(enc(4'h8));
    settle();
    chk(nmark - m0 == 1, "R4 R3 realign after bad", nmark - m0, 1);
  endtask

  initial begin
    int id;
    id = 0;
    for (int off = 0; off < 5; off++)
      for (int g = 0; g < 2; g++)
        for (int s = 0; s < 2; s++) begin
          run(id, off, g, s[0]);
          id++;
        end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #750000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule